// File: doc/BRIEF.md
# Load-Level CPU Clock and Voltage Selector

This block keeps four CPU operating points, one per load level, and drives the clock and voltage selection codes of the CPU domain from the level that software picks. Each operating point is a 16-bit entry. It holds a divider code, a clock-source select, a PLL select and a voltage-set index. Two 32-bit configuration registers hold two entries each. A load register names the active level. Level 0 is the fastest, and the CPU frequency at a level is the base frequency divided by that level's divider.

A dynamic-mode register carries one enable bit for each output and a master enable. While the master enable is set, the configuration and load registers are frozen. Software therefore clears the master bit, rewrites the entries and the load level, and writes the dynamic-mode register last. The block does not generate clocks and does not drive a regulator. It only presents registered select and divide codes, and it raises a one-cycle strobe whenever any of these codes changes.

Top module: `dvfs_level_sel`

## Requirements
- R1: After reset every register reads 0, the outputs are clock source 0, PLL select 0, divider 1 and voltage index 0, and `level_change` is low.
- R2: The register at byte offset 0x18 and the one at 0x1C store all 32 written bits, and so does the register at 0x24. The register at 0x30 stores bits [1:0] and reads 0 in bits [31:2]. A read returns its data on `bus_rdata` one clock after `bus_rd`. Any other offset reads 0 and ignores writes.
- R3: While bit 31 of register 0x24 is set, writes to 0x18, 0x1C and 0x30 leave them unchanged. Register 0x24 itself stays writable at all times.
- R4: Level 0 is 0x18[31:16], level 1 is 0x18[15:0], level 2 is 0x1C[31:16] and level 3 is 0x1C[15:0]. The active level is 0x30[1:0].
- R5: Inside an entry, bits [15:13] hold the divider, bit 11 the clock source, bits [10:9] the PLL select and bits [7:6] the voltage index.
- R6: An output takes the active level's field only when bit 31 of 0x24 is set together with that output's own bit: 26 for the clock source, 28 for the PLL select, 29 for the divider and 30 for the voltage index. Otherwise the output takes its default from R1.
- R7: A divider field of 0 is driven as 1, so `cpu_div` is never 0.
- R8: The outputs are registered. They take their new values on the clock edge after the edge that writes the register causing the change.
- R9: `level_change` is high for exactly the first cycle in which any output holds a new value, and low in every other cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_wr | input | 1 | Write strobe, one cycle per write |
| bus_rd | input | 1 | Read strobe |
| bus_addr | input | ADDR_W | Byte offset of the register |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, valid one cycle after bus_rd |
| cpu_clk_src | output | 1 | Clock-source select (1 = PLL path) |
| cpu_pll_sel | output | 2 | PLL select |
| cpu_div | output | 3 | Clock divide ratio, 1 to 7 |
| cpu_vset | output | 2 | Voltage-set index |
| level_change | output | 1 | One-cycle strobe when any output changes |

## Verification
A register write takes effect at the edge that samples `bus_wr`. The outputs and `level_change` then respond at the next edge, two edges after the write is driven. The bench drives each write on a falling edge and lets one more full cycle pass. It compares the four codes and the strobe on the falling edge after the output edge, and checks one cycle later that the strobe has dropped. A read is compared on the falling edge that follows the capture edge, and locked writes are shown to have no effect by reading the registers back.

// File: rtl/dvfs_sel_pkg.sv
package dvfs_sel_pkg;
  localparam int NUM_LEVELS = 4;
  localparam int LVL_W      = $clog2(NUM_LEVELS);
  localparam int ENTRY_W    = 16;

  // entry field positions (decoded by the selector)
  localparam int DIV_LSB  = 13;
  localparam int SRC_BIT  = 11;
  localparam int PLL_LSB  = 9;
  localparam int VSET_LSB = 6;

  // dynamic-mode register enable bits
  localparam int EN_SRC_BIT = 26;
  localparam int EN_PLL_BIT = 28;
  localparam int EN_DIV_BIT = 29;
  localparam int EN_VS_BIT  = 30;
  localparam int MASTER_BIT = 31;

  typedef struct packed {
    logic       src;
    logic [1:0] pll;
    logic [2:0] div;
    logic [1:0] vset;
  } applied_t;

  localparam applied_t APPLIED_DEFAULT = '{src: 1'b0, pll: 2'd0, div: 3'd1, vset: 2'd0};
endpackage

// File: rtl/dvfs_regfile.sv
module dvfs_regfile #(
  parameter int ADDR_W   = 8,
  parameter int OFF_CFGA = 'h18,
  parameter int OFF_CFGB = 'h1C,
  parameter int OFF_DYN  = 'h24,
  parameter int OFF_LOAD = 'h30
) (
  input  logic                           clk,
  input  logic                           rst,
  input  logic                           bus_wr,
  input  logic                           bus_rd,
  input  logic [ADDR_W-1:0]              bus_addr,
  input  logic [31:0]                    bus_wdata,
  output logic [31:0]                    bus_rdata,
  output logic [31:0]                    cfg_a,
  output logic [31:0]                    cfg_b,
  output logic [31:0]                    dyn,
  output logic [dvfs_sel_pkg::LVL_W-1:0] load_lvl
);
  import dvfs_sel_pkg::*;

  localparam logic [ADDR_W-1:0] A_CFGA = ADDR_W'(OFF_CFGA);
  localparam logic [ADDR_W-1:0] A_CFGB = ADDR_W'(OFF_CFGB);
  localparam logic [ADDR_W-1:0] A_DYN  = ADDR_W'(OFF_DYN);
  localparam logic [ADDR_W-1:0] A_LOAD = ADDR_W'(OFF_LOAD);

  logic locked;
  assign locked = dyn[MASTER_BIT];

  always_ff @(posedge clk) begin
    if (rst) begin
      cfg_a    <= '0;
      cfg_b    <= '0;
      dyn      <= '0;
      load_lvl <= '0;
    end else if (bus_wr) begin
      if (bus_addr == A_DYN) dyn <= bus_wdata;
      if (!locked) begin
        if (bus_addr == A_CFGA) cfg_a    <= bus_wdata;
        if (bus_addr == A_CFGB) cfg_b    <= bus_wdata;
        if (bus_addr == A_LOAD) load_lvl <= bus_wdata[LVL_W-1:0];
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      bus_rdata <= '0;
    end else if (bus_rd) begin
      case (bus_addr)
        A_CFGA:  bus_rdata <= cfg_a;
        A_CFGB:  bus_rdata <= cfg_b;
        A_DYN:   bus_rdata <= dyn;
        A_LOAD:  bus_rdata <= {{(32-LVL_W){1'b0}}, load_lvl};
        default: bus_rdata <= '0;
      endcase
    end
  end
endmodule

// File: rtl/dvfs_level_mux.sv
module dvfs_level_mux (
  input  logic [31:0]                    cfg_a,
  input  logic [31:0]                    cfg_b,
  input  logic [dvfs_sel_pkg::LVL_W-1:0] load_lvl,
  input  logic                           master_en,
  input  logic                           en_src,
  input  logic                           en_pll,
  input  logic                           en_div,
  input  logic                           en_vset,
  output dvfs_sel_pkg::applied_t         nxt
);
  import dvfs_sel_pkg::*;

  localparam int PER_REG = 32 / ENTRY_W;

  logic [1:0][31:0]        cfg_pair;
  logic [ENTRY_W-1:0]      entry [NUM_LEVELS];
  logic [ENTRY_W-1:0]      act;
  logic [2:0]              raw_div;

  assign cfg_pair = {cfg_b, cfg_a};

  // even levels live in the upper half-word, odd levels in the lower one
  for (genvar i = 0; i < NUM_LEVELS; i++) begin : g_lvl
    localparam int REG_IDX = i / PER_REG;
    localparam int LSB     = ((i % PER_REG) == 0) ? ENTRY_W : 0;
    assign entry[i] = cfg_pair[REG_IDX][LSB +: ENTRY_W];
  end

  assign act     = entry[load_lvl];
  assign raw_div = act[DIV_LSB +: 3];

  always_comb begin
    nxt = APPLIED_DEFAULT;
    if (master_en) begin
      if (en_src)  nxt.src  = act[SRC_BIT];
      if (en_pll)  nxt.pll  = act[PLL_LSB +: 2];
      if (en_div)  nxt.div  = (raw_div == 3'd0) ? 3'd1 : raw_div;
      if (en_vset) nxt.vset = act[VSET_LSB +: 2];
    end
  end
endmodule

// File: rtl/dvfs_out_stage.sv
module dvfs_out_stage (
  input  logic                   clk,
  input  logic                   rst,
  input  dvfs_sel_pkg::applied_t nxt,
  output dvfs_sel_pkg::applied_t cur,
  output logic                   changed
);
  import dvfs_sel_pkg::*;

  always_ff @(posedge clk) begin
    if (rst) begin
      cur     <= APPLIED_DEFAULT;
      changed <= 1'b0;
    end else begin
      cur     <= nxt;
      changed <= (nxt != cur);
    end
  end
endmodule

// File: rtl/dvfs_level_sel.sv
module dvfs_level_sel #(
  parameter int ADDR_W   = 8,
  parameter int OFF_CFGA = 'h18,
  parameter int OFF_CFGB = 'h1C,
  parameter int OFF_DYN  = 'h24,
  parameter int OFF_LOAD = 'h30
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              bus_wr,
  input  logic              bus_rd,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [31:0]       bus_wdata,
  output logic [31:0]       bus_rdata,
  output logic              cpu_clk_src,
  output logic [1:0]        cpu_pll_sel,
  output logic [2:0]        cpu_div,
  output logic [1:0]        cpu_vset,
  output logic              level_change
);
  import dvfs_sel_pkg::*;

  logic [31:0]      cfg_a, cfg_b, dyn;
  logic [LVL_W-1:0] load_lvl;
  applied_t         nxt, cur;

  dvfs_regfile #(
    .ADDR_W(ADDR_W), .OFF_CFGA(OFF_CFGA), .OFF_CFGB(OFF_CFGB),
    .OFF_DYN(OFF_DYN), .OFF_LOAD(OFF_LOAD)
  ) u_regs (
    .clk(clk), .rst(rst), .bus_wr(bus_wr), .bus_rd(bus_rd),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .cfg_a(cfg_a), .cfg_b(cfg_b), .dyn(dyn), .load_lvl(load_lvl)
  );

  dvfs_level_mux u_mux (
    .cfg_a(cfg_a), .cfg_b(cfg_b), .load_lvl(load_lvl),
    .master_en(dyn[MASTER_BIT]), .en_src(dyn[EN_SRC_BIT]),
    .en_pll(dyn[EN_PLL_BIT]), .en_div(dyn[EN_DIV_BIT]),
    .en_vset(dyn[EN_VS_BIT]), .nxt(nxt)
  );

  dvfs_out_stage u_out (
    .clk(clk), .rst(rst), .nxt(nxt), .cur(cur), .changed(level_change)
  );

  assign cpu_clk_src = cur.src;
  assign cpu_pll_sel = cur.pll;
  assign cpu_div     = cur.div;
  assign cpu_vset    = cur.vset;
endmodule

// File: rtl/dvfs_level_sel_chk.sv
module dvfs_level_sel_chk #(
  parameter int ADDR_W   = 8,
  parameter int OFF_CFGA = 'h18,
  parameter int OFF_CFGB = 'h1C,
  parameter int OFF_LOAD = 'h30
) (
  input logic              clk,
  input logic              rst,
  input logic              bus_wr,
  input logic [ADDR_W-1:0] bus_addr,
  input logic [31:0]       cfg_a,
  input logic [31:0]       cfg_b,
  input logic [31:0]       dyn,
  input logic [1:0]        load_lvl,
  input logic              cpu_clk_src,
  input logic [1:0]        cpu_pll_sel,
  input logic [2:0]        cpu_div,
  input logic [1:0]        cpu_vset,
  input logic              level_change
);
  logic [7:0] outs;
  assign outs = {cpu_clk_src, cpu_pll_sel, cpu_div, cpu_vset};

  assert_lock_cfga_R3: assert property (@(posedge clk) disable iff (rst)
    (bus_wr && dyn[31] && bus_addr == ADDR_W'(OFF_CFGA)) |=> $stable(cfg_a));

  assert_lock_cfgb_R3: assert property (@(posedge clk) disable iff (rst)
    (bus_wr && dyn[31] && bus_addr == ADDR_W'(OFF_CFGB)) |=> $stable(cfg_b));

  assert_lock_load_R3: assert property (@(posedge clk) disable iff (rst)
    (bus_wr && dyn[31] && bus_addr == ADDR_W'(OFF_LOAD)) |=> $stable(load_lvl));

  assert_gate_default_R6: assert property (@(posedge clk) disable iff (rst)
    !dyn[31] |=> (cpu_clk_src == 1'b0 && cpu_pll_sel == 2'd0 && cpu_div == 3'd1 && cpu_vset == 2'd0));

  assert_div_nonzero_R7: assert property (@(posedge clk) disable iff (rst)
    cpu_div != 3'd0);

  assert_strobe_change_R9: assert property (@(posedge clk) disable iff (rst)
    level_change |-> (outs != $past(outs)));

  assert_strobe_quiet_R9: assert property (@(posedge clk) disable iff (rst)
    !level_change |-> $stable(outs));
endmodule

bind dvfs_level_sel dvfs_level_sel_chk #(
  .ADDR_W(ADDR_W), .OFF_CFGA(OFF_CFGA), .OFF_CFGB(OFF_CFGB), .OFF_LOAD(OFF_LOAD)
) u_chk (
  .clk(clk), .rst(rst), .bus_wr(bus_wr), .bus_addr(bus_addr),
  .cfg_a(cfg_a), .cfg_b(cfg_b), .dyn(dyn), .load_lvl(load_lvl),
  .cpu_clk_src(cpu_clk_src), .cpu_pll_sel(cpu_pll_sel), .cpu_div(cpu_div),
  .cpu_vset(cpu_vset), .level_change(level_change)
);

// File: tb/dvfs_level_sel_tb.sv
module dvfs_level_sel_tb;
  localparam int ADDR_W = 8;
  localparam logic [7:0] A_CFGA = 8'h18, A_CFGB = 8'h1C, A_DYN = 8'h24, A_LOAD = 8'h30;
  localparam logic [31:0] DYN_ALL = 32'hF400_0000;

  logic clk = 1'b0, rst = 1'b1;
  logic bus_wr = 1'b0, bus_rd = 1'b0;
  logic [7:0]  bus_addr = '0;
  logic [31:0] bus_wdata = '0, bus_rdata;
  logic cpu_clk_src, level_change;
  logic [1:0] cpu_pll_sel, cpu_vset;
  logic [2:0] cpu_div;

  int n_chk = 0, n_bad = 0;

  // bench model of the registers
  logic [31:0] m_a = '0, m_b = '0, m_dyn = '0;
  logic [1:0]  m_load = '0;
  logic [7:0]  prev_exp = 8'b0_00_001_00;

  always #4 clk = ~clk;

  dvfs_level_sel #(.ADDR_W(ADDR_W)) u_dut (
    .clk(clk), .rst(rst), .bus_wr(bus_wr), .bus_rd(bus_rd), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .cpu_clk_src(cpu_clk_src),
    .cpu_pll_sel(cpu_pll_sel), .cpu_div(cpu_div), .cpu_vset(cpu_vset),
    .level_change(level_change)
  );

  function automatic logic [15:0] mk_entry(input logic [2:0] d, input logic s,
                                           input logic [1:0] p, input logic [1:0] v);
    return {d, 1'b0, s, p, 1'b0, v, 6'b0};  // R5 layout
  endfunction

  // expected {src, pll, div, vset} from the requirements R4..R7
  function automatic logic [7:0] exp_out();
    logic [15:0] e;
    logic s; logic [1:0] p, v; logic [2:0] d;
    case (m_load)
      2'd0: e = m_a[31:16];
      2'd1: e = m_a[15:0];
      2'd2: e = m_b[31:16];
      default: e = m_b[15:0];
    endcase
    s = 1'b0; p = 2'd0; d = 3'd1; v = 2'd0;
    if (m_dyn[31]) begin
      if (m_dyn[26]) s = e[11];
      if (m_dyn[28]) p = e[10:9];
      if (m_dyn[29]) d = (e[15:13] == 3'd0) ? 3'd1 : e[15:13];
      if (m_dyn[30]) v = e[7:6];
    end
    return {s, p, d, v};
  endfunction

  function automatic logic [31:0] exp_read(input logic [7:0] a);
    case (a)
      A_CFGA: return m_a;
      A_CFGB: return m_b;
      A_DYN:  return m_dyn;
      A_LOAD: return {30'b0, m_load};
      default: return 32'b0;
    endcase
  endfunction

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] expv);
    n_chk++;
    if (act !== expv) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, expv);
    end
  endtask

  // write, then wait until the outputs have responded (R8) and check them
  task automatic wr_chk(input logic [7:0] a, input logic [31:0] d, input string req);
    logic [7:0] e;
    @(negedge clk);
    bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_wr = 1'b0;
    if (a == A_DYN) m_dyn = d;
    else if (!m_dyn[31]) begin
      if (a == A_CFGA) m_a = d;
      if (a == A_CFGB) m_b = d;
      if (a == A_LOAD) m_load = d[1:0];
    end
    @(negedge clk);
    e = exp_out();
    check({req, " outputs R8"}, {24'b0, cpu_clk_src, cpu_pll_sel, cpu_div, cpu_vset}, {24'b0, e});
    check("strobe R9", {31'b0, level_change}, {31'b0, (e != prev_exp)});
    prev_exp = e;
  endtask

  task automatic rd_chk(input logic [7:0] a, input string req);
    @(negedge clk);
    bus_rd = 1'b1; bus_addr = a;
    @(negedge clk);
    bus_rd = 1'b0;
    check(req, bus_rdata, exp_read(a));
  endtask

  task automatic quiet_chk();
    @(negedge clk);
    check("strobe drop R9", {31'b0, level_change}, 32'b0);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog actual=running expected=finished");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    void'($urandom(32'd20240611));
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R1 reset state
    check("reset outputs R1", {24'b0, cpu_clk_src, cpu_pll_sel, cpu_div, cpu_vset}, {24'b0, 8'b0_00_001_00});
    check("reset strobe R1", {31'b0, level_change}, 32'b0);
    rd_chk(A_CFGA, "reset read R1");
    rd_chk(A_DYN, "reset read R1");
    rd_chk(A_LOAD, "reset read R1");

    // R4/R5 program levels; R6 outputs hold defaults while master is off
    wr_chk(A_CFGA, {mk_entry(3'd2, 1'b1, 2'd3, 2'd1), mk_entry(3'd3, 1'b0, 2'd1, 2'd2)}, "program R6");
    wr_chk(A_CFGB, {mk_entry(3'd5, 1'b1, 2'd2, 2'd3), mk_entry(3'd0, 1'b1, 2'd1, 2'd0)}, "program R6");
    rd_chk(A_CFGA, "readback R2");
    rd_chk(A_CFGB, "readback R2");
    wr_chk(A_DYN, DYN_ALL, "enable level0 R4");
    quiet_chk();
    // R3 lock: load and cfg writes ignored while master set
    wr_chk(A_LOAD, 32'd2, "locked load R3");
    rd_chk(A_LOAD, "locked load readback R3");
    wr_chk(A_CFGA, 32'hFFFF_FFFF, "locked cfg R3");
    rd_chk(A_CFGA, "locked cfg readback R3");
    // R4 level 2, then level 3 with divider 0 (R7)
    wr_chk(A_DYN, 32'h0, "disable R6");
    wr_chk(A_LOAD, 32'hFFFF_FFFE, "load level2 R4");
    rd_chk(A_LOAD, "load upper bits R2");
    wr_chk(A_DYN, DYN_ALL, "level2 R4");
    wr_chk(A_DYN, 32'h0, "disable R6");
    wr_chk(A_LOAD, 32'd3, "load level3 R4");
    wr_chk(A_DYN, DYN_ALL, "div zero R7");
    // R6 partial enables
    wr_chk(A_DYN, 32'h9000_0000, "pll only R6");
    wr_chk(A_DYN, 32'h7400_0000, "no master R6");
    wr_chk(A_DYN, 32'hA400_0000, "div and src R6");
    // R2 unmapped address
    wr_chk(8'h20, 32'hDEAD_BEEF, "unmapped write R2");
    rd_chk(8'h20, "unmapped read R2");
    rd_chk(A_DYN, "dyn readback R2");

    // constrained random mix
    for (int i = 0; i < 400; i++) begin
      int unsigned pick;
      logic [31:0] d;
      logic [7:0] a;
      pick = $urandom_range(0, 9);
      d = $urandom();
      case (pick)
        0, 1: a = A_CFGA;
        2, 3: a = A_CFGB;
        4, 5: a = A_LOAD;
        6, 7, 8: begin a = A_DYN; d = d & 32'hF400_0000 | (d & 32'h0BFF_FFFF); end
        default: a = 8'($urandom_range(0, 63) * 4);
      endcase
      wr_chk(a, d, "random R4 R6");
      if ((i % 8) == 0) quiet_chk();
      if ((i % 5) == 0) rd_chk(8'($urandom_range(0, 15) * 4) + 8'h18, "random read R2");
    end

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule